// File: doc/BRIEF.md
# Display Controller Host Command Port

This block sits between a host processor and the internals of a graphic LCD controller. The host drives 8-bit bytes on a parallel bus, together with a data/instruction select, a value/select qualifier and one-cycle write and read strobes. An instruction write either picks one of 32 internal register numbers or stores a byte into the register picked last. A data write or read goes to display memory, or to a temperature-table memory, at the location held by the address counters. After each such access the counter in use steps on by itself, so the host can stream a run of bytes without reloading the address.

Two counters address display memory: a row counter of 0..63 and a column counter of 0..31. A mode bit selects which one of them steps, and a direction bit selects up or down. A third counter of 0..127 addresses the temperature table and only counts up. A status read returns the mode flags in one cycle. A display-memory read uses a registered memory port with one cycle of latency. A three-state sequencer handles it: ST_IDLE goes to ST_RD_ISSUE on an accepted data read, ST_RD_ISSUE always goes to ST_RD_WAIT, and ST_RD_WAIT always returns to ST_IDLE, capturing the read byte and stepping the counter.

Top module: `lcdif_host_port`

## Requirements
- R1: With bus_di=1 a write strobe is a data write. In the next cycle mem_we is high for one cycle, mem_wdata carries the byte, and mem_addr carries the address as it was before the step. With bus_di=0 the byte is an instruction and never reaches memory.
- R2: An instruction write with bus_rs=0 selects register number bus_din[4:0]. An instruction write with bus_rs=1 stores the byte into the selected register. The selection stays in place across any number of value writes.
- R3: Register 0 holds three fields: bit 2 selects the memory (1 = display, 0 = temperature table), bit 1 selects the counter (1 = column, 0 = row) and bit 0 sets the direction (1 = up, 0 = down). Register 1 holds two fields: bit 1 is normal mode (0 = power save) and bit 0 is display on.
- R4: A write to register 5 with bit 7 = 0 loads the row counter from bits 5:0. With bit 7 = 1 it loads the column counter from bits 4:0. A write to register 9 loads the temperature counter from bits 6:0. The display address on mem_addr is {row, column}, with the row in bits 10:5 and the column in bits 4:0. A temperature address sits in bits 6:0, with zeros above and mem_tsel=1.
- R5: Each display data access steps only the selected counter, in the selected direction. The other counter does not move.
- R6: An up-count wraps from its maximum to 0. A down-count wraps from 0 to its maximum.
- R7: In temperature-table mode each access increments the temperature counter, whatever the direction bit says.
- R8: A data read raises mem_re for one cycle, one cycle after the strobe. The read byte appears on host_rdata, with host_rvalid high for one cycle, two cycles after mem_re. The counter steps in that same cycle.
- R9: An instruction read returns a status byte one cycle later, with host_rvalid high. The byte is {000, memory select, normal mode, display on, counter select, direction}, from bit 7 down to bit 0.
- R10: A value write to register 28..31 has no effect. A value write to any other register number outside 0, 1, 5 and 9 also has no effect.
- R11: A write strobe and a read strobe in the same cycle take the write and drop the read. Strobes that arrive while a read is in flight are ignored.
- R12: After reset (rst_n low at a clock edge) the following hold:
  - every counter is zero;
  - register 0 holds temperature memory, row counter and direction up;
  - the display is off and power-save is selected;
  - the selected register number is 0;
  - mem_addr, mem_wdata and host_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_di | input | 1 | 1 = display data, 0 = instruction |
| bus_rs | input | 1 | For instruction writes: 0 = select register, 1 = write value |
| bus_din | input | 8 | Byte from the host |
| host_rdata | output | 8 | Read byte or status byte |
| host_rvalid | output | 1 | host_rdata updated this cycle |
| mem_we | output | 1 | Memory write pulse |
| mem_re | output | 1 | Memory read pulse |
| mem_tsel | output | 1 | 1 = temperature table, 0 = display memory |
| mem_addr | output | 11 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after mem_re |

## Verification
Two functions can land in the same cycle. A write strobe can meet a read strobe, and a new strobe can meet the completion of a read that is still stepping the counter. The bench provokes the first by raising both strobes together. It provokes the second by issuing a data write and a status read while a read is in ST_RD_ISSUE or ST_RD_WAIT. A behavioural model compares every output in every cycle. It expects the write alone to be taken, the in-flight strobes to leave memory and the counters untouched, and only the completing read to step the address.

// File: rtl/lcdif_pkg.sv
package lcdif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_ISSUE = 2'd1,
        ST_RD_WAIT  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic msel_disp;   // 1: display memory, 0: temperature table
        logic cnt_col;     // 1: column counter steps, 0: row counter
        logic dir_up;      // 1: up, 0: down
    } mode_t;

    localparam int REG_MODE       = 0;
    localparam int REG_DISP       = 1;
    localparam int REG_ADDR       = 5;
    localparam int REG_TADDR      = 9;
    localparam int REG_TEST_FIRST = 28;

endpackage

// File: rtl/lcdif_step_ctr.sv
module lcdif_step_ctr #(
    parameter int W       = 6,
    parameter bit UP_ONLY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] QMAX = '1;

    logic dir_up;

    generate
        if (UP_ONLY) begin : g_up_only
            assign dir_up = 1'b1;
            // R7
            up_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                step && !load && !up |=> q == W'($past(q) + 1'b1));
        end else begin : g_up_down
            assign dir_up = up;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            if (dir_up) q <= q + 1'b1;
            else        q <= q - 1'b1;
        end
    end

    // R6
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && dir_up && q == QMAX |=> q == '0);
    // R6
    wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && !dir_up && q == '0 |=> q == QMAX);

endmodule

// File: rtl/lcdif_cfg_regs.sv
module lcdif_cfg_regs
    import lcdif_pkg::*;
#(
    parameter int DW    = 8,
    parameter int RSELW = 5,
    parameter int XW    = 6,
    parameter int YW    = 5,
    parameter int TW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_val,
    input  logic [DW-1:0] din,
    output mode_t         mode,
    output logic          disp_nf,
    output logic          disp_on,
    output logic          ld_x,
    output logic          ld_y,
    output logic          ld_t,
    output logic [XW-1:0] ld_x_val,
    output logic [YW-1:0] ld_y_val,
    output logic [TW-1:0] ld_t_val
);
    logic [RSELW-1:0] sel_q;
    logic             val_wr;

    assign val_wr   = cfg_wr && cfg_val;
    assign ld_x     = val_wr && (sel_q == RSELW'(REG_ADDR)) && !din[DW-1];
    assign ld_y     = val_wr && (sel_q == RSELW'(REG_ADDR)) &&  din[DW-1];
    assign ld_t     = val_wr && (sel_q == RSELW'(REG_TADDR));
    assign ld_x_val = din[XW-1:0];
    assign ld_y_val = din[YW-1:0];
    assign ld_t_val = din[TW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            mode    <= '{msel_disp: 1'b0, cnt_col: 1'b0, dir_up: 1'b1};
            disp_nf <= 1'b0;
            disp_on <= 1'b0;
        end else if (cfg_wr && !cfg_val) begin
            sel_q <= din[RSELW-1:0];
        end else if (val_wr) begin
            if (sel_q == RSELW'(REG_MODE)) begin
                mode <= '{msel_disp: din[2], cnt_col: din[1], dir_up: din[0]};
            end
            if (sel_q == RSELW'(REG_DISP)) begin
                disp_nf <= din[1];
                disp_on <= din[0];
            end
        end
    end

    // R3
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_wr && sel_q == RSELW'(REG_MODE) |=> mode == $past(din[2:0]));
    // R10
    test_reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_wr && sel_q >= RSELW'(REG_TEST_FIRST)
        |=> $stable(mode) && $stable(disp_nf) && $stable(disp_on));

endmodule

// File: rtl/lcdif_host_seq.sv
module lcdif_host_seq
    import lcdif_pkg::*;
#(
    parameter int DW = 8,
    parameter int XW = 6,
    parameter int YW = 5,
    parameter int TW = 7,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_di,
    input  logic [DW-1:0] bus_din,
    input  mode_t         mode,
    input  logic          disp_nf,
    input  logic          disp_on,
    input  logic [XW-1:0] x_q,
    input  logic [YW-1:0] y_q,
    input  logic [TW-1:0] t_q,
    input  logic [DW-1:0] mem_rdata,
    output logic          cfg_wr,
    output logic          step_x,
    output logic          step_y,
    output logic          step_t,
    output logic          mem_we,
    output logic          mem_re,
    output logic          mem_tsel,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid
);
    seq_state_t    st, st_nx;
    logic          idle, acc_wr, acc_rd, stat_rd, step_any;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] status_b;

    assign idle     = (st == ST_IDLE);
    assign acc_wr   = idle && bus_wr && bus_di;
    assign cfg_wr   = idle && bus_wr && !bus_di;
    assign acc_rd   = idle && !bus_wr && bus_rd && bus_di;
    assign stat_rd  = idle && !bus_wr && bus_rd && !bus_di;
    assign step_any = acc_wr || (st == ST_RD_WAIT);
    assign step_t   = step_any && !mode.msel_disp;
    assign step_y   = step_any &&  mode.msel_disp &&  mode.cnt_col;
    assign step_x   = step_any &&  mode.msel_disp && !mode.cnt_col;
    assign cur_addr = mode.msel_disp ? AW'({x_q, y_q}) : AW'(t_q);
    assign status_b = DW'({mode.msel_disp, disp_nf, disp_on, mode.cnt_col, mode.dir_up});

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (acc_rd) st_nx = ST_RD_ISSUE;
            ST_RD_ISSUE: st_nx = ST_RD_WAIT;
            ST_RD_WAIT:  st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we      <= 1'b0;
            mem_re      <= 1'b0;
            mem_tsel    <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            mem_we      <= 1'b0;
            mem_re      <= 1'b0;
            host_rvalid <= 1'b0;
            if (acc_wr) begin
                mem_we    <= 1'b1;
                mem_wdata <= bus_din;
                mem_addr  <= cur_addr;
                mem_tsel  <= !mode.msel_disp;
            end
            if (acc_rd) begin
                mem_re   <= 1'b1;
                mem_addr <= cur_addr;
                mem_tsel <= !mode.msel_disp;
            end
            if (stat_rd) begin
                host_rdata  <= status_b;
                host_rvalid <= 1'b1;
            end
            if (st == ST_RD_WAIT) begin
                host_rdata  <= mem_rdata;
                host_rvalid <= 1'b1;
            end
        end
    end

    // R11
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_IDLE |=> !mem_we);
    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);
    // R8
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ##2 host_rvalid);
    // R9
    status_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> host_rvalid && host_rdata[0] == $past(mode.dir_up));

endmodule

// File: rtl/lcdif_host_port.sv
module lcdif_host_port
    import lcdif_pkg::*;
#(
    parameter int DW    = 8,
    parameter int RSELW = 5,
    parameter int XW    = 6,
    parameter int YW    = 5,
    parameter int TW    = 7,
    localparam int AW   = ((XW + YW) > TW) ? (XW + YW) : TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_di,
    input  logic          bus_rs,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic          mem_we,
    output logic          mem_re,
    output logic          mem_tsel,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    mode_t         mode;
    logic          disp_nf, disp_on, cfg_wr;
    logic          ld_x, ld_y, ld_t, step_x, step_y, step_t;
    logic [XW-1:0] ld_x_val, x_q;
    logic [YW-1:0] ld_y_val, y_q;
    logic [TW-1:0] ld_t_val, t_q;

    lcdif_cfg_regs #(.DW(DW), .RSELW(RSELW), .XW(XW), .YW(YW), .TW(TW)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_val(bus_rs), .din(bus_din),
        .mode(mode), .disp_nf(disp_nf), .disp_on(disp_on),
        .ld_x(ld_x), .ld_y(ld_y), .ld_t(ld_t),
        .ld_x_val(ld_x_val), .ld_y_val(ld_y_val), .ld_t_val(ld_t_val)
    );

    lcdif_step_ctr #(.W(XW), .UP_ONLY(1'b0)) i_row_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_x), .load_val(ld_x_val),
        .step(step_x), .up(mode.dir_up), .q(x_q)
    );

    lcdif_step_ctr #(.W(YW), .UP_ONLY(1'b0)) i_col_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_y), .load_val(ld_y_val),
        .step(step_y), .up(mode.dir_up), .q(y_q)
    );

    lcdif_step_ctr #(.W(TW), .UP_ONLY(1'b1)) i_tmp_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_t), .load_val(ld_t_val),
        .step(step_t), .up(mode.dir_up), .q(t_q)
    );

    lcdif_host_seq #(.DW(DW), .XW(XW), .YW(YW), .TW(TW), .AW(AW)) i_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_di(bus_di),
        .bus_din(bus_din), .mode(mode), .disp_nf(disp_nf), .disp_on(disp_on),
        .x_q(x_q), .y_q(y_q), .t_q(t_q), .mem_rdata(mem_rdata),
        .cfg_wr(cfg_wr), .step_x(step_x), .step_y(step_y), .step_t(step_t),
        .mem_we(mem_we), .mem_re(mem_re), .mem_tsel(mem_tsel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    // R5
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_x, step_y, step_t}));
    // R5
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_x && !ld_y |=> $stable(y_q));

endmodule

// File: tb/test_lcdif_host_port.sv
module test_lcdif_host_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_di = 1'b0, bus_rs = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] host_rdata, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic       host_rvalid, mem_we, mem_re, mem_tsel;
    logic [10:0] mem_addr;

    always #5 clk = ~clk;

    lcdif_host_port i_lcdif_host_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_di(bus_di),
        .bus_rs(bus_rs), .bus_din(bus_din), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .mem_we(mem_we), .mem_re(mem_re),
        .mem_tsel(mem_tsel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // memory responder with one cycle of read latency
    logic [7:0] dmem [0:2047];
    logic [7:0] tmem [0:127];
    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_tsel) tmem[mem_addr[6:0]] <= mem_wdata;
            else          dmem[mem_addr]      <= mem_wdata;
        end
        if (mem_re) mem_rdata <= mem_tsel ? tmem[mem_addr[6:0]] : dmem[mem_addr];
    end

    // behavioural reference model
    int m_dmem [2048];
    int m_tmem [128];
    int m_st = 0, m_sel = 0, m_msel = 0, m_col = 0, m_up = 1, m_nf = 0, m_dp = 0;
    int m_x = 0, m_y = 0, m_t = 0, pend = 0;
    int e_we = 0, e_re = 0, e_ts = 0, e_addr = 0, e_wd = 0, e_rd = 0, e_rv = 0;

    function automatic int cur_addr();
        return (m_msel != 0) ? (m_x * 32 + m_y) : m_t;
    endfunction

    task automatic model_step();
        if (m_msel == 0)     m_t = (m_t + 1) % 128;
        else if (m_col != 0) m_y = (m_up != 0) ? (m_y + 1) % 32 : (m_y + 31) % 32;
        else                 m_x = (m_up != 0) ? (m_x + 1) % 64 : (m_x + 63) % 64;
    endtask

    always @(posedge clk) begin
        int b;
        b = int'(bus_din);
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_msel = 0; m_col = 0; m_up = 1; m_nf = 0; m_dp = 0;
            m_x = 0; m_y = 0; m_t = 0;
            e_we = 0; e_re = 0; e_ts = 0; e_addr = 0; e_wd = 0; e_rd = 0; e_rv = 0;
        end else begin
            e_we = 0; e_re = 0; e_rv = 0;
            if (m_st == 0) begin
                if (bus_wr) begin
                    if (bus_di) begin
                        e_we = 1; e_wd = b; e_addr = cur_addr(); e_ts = (m_msel == 0);
                        if (m_msel != 0) m_dmem[e_addr] = b; else m_tmem[e_addr] = b;
                        model_step();
                    end else if (!bus_rs) begin
                        m_sel = b % 32;
                    end else begin
                        case (m_sel)
                            0: begin m_msel = (b >> 2) & 1; m_col = (b >> 1) & 1; m_up = b & 1; end
                            1: begin m_nf = (b >> 1) & 1; m_dp = b & 1; end
                            5: if (b >= 128) m_y = b % 32; else m_x = b % 64;
                            9: m_t = b % 128;
                            default: ;
                        endcase
                    end
                end else if (bus_rd) begin
                    if (bus_di) begin
                        e_re = 1; e_addr = cur_addr(); e_ts = (m_msel == 0);
                        pend = (m_msel != 0) ? m_dmem[e_addr] : m_tmem[e_addr];
                        m_st = 1;
                    end else begin
                        e_rd = m_msel * 16 + m_nf * 8 + m_dp * 4 + m_col * 2 + m_up;
                        e_rv = 1;
                    end
                end
            end else if (m_st == 1) begin
                m_st = 2;
            end else begin
                e_rd = pend; e_rv = 1; model_step(); m_st = 0;
            end
        end
    end

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R12";
    bit    done = 1'b0;

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("mem_we", int'(mem_we), e_we);
            chk("mem_re", int'(mem_re), e_re);
            chk("mem_tsel", int'(mem_tsel), e_ts);
            chk("mem_addr", int'(mem_addr), e_addr);
            chk("mem_wdata", int'(mem_wdata), e_wd);
            chk("host_rvalid", int'(host_rvalid), e_rv);
            chk("host_rdata", int'(host_rdata), e_rd);
        end
    end

    task automatic cyc(bit w, bit r, bit d, bit s, logic [7:0] v);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_di = d; bus_rs = s; bus_din = v;
    endtask
    task automatic idle();                       cyc(0, 0, 0, 0, 8'h00); endtask
    task automatic setreg(int n, logic [7:0] v); cyc(1, 0, 0, 0, 8'(n)); cyc(1, 0, 0, 1, v); endtask
    task automatic dwr(logic [7:0] v);           cyc(1, 0, 1, 0, v); endtask
    task automatic stat();                       cyc(0, 1, 0, 0, 8'h00); endtask
    task automatic drd();
        cyc(0, 1, 1, 0, 8'h00);
        cyc(1, 0, 1, 0, 8'hEE);   // ignored, read in flight (R11)
        cyc(0, 1, 0, 0, 8'h00);   // ignored, read in flight (R11)
    endtask

    task automatic summary();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin dmem[i] = 8'h00; m_dmem[i] = 0; end
        for (int i = 0; i < 128; i++)  begin tmem[i] = 8'h00; m_tmem[i] = 0; end
        cur_req = "R12";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(); stat(); idle();

        cur_req = "R3";
        setreg(1, 8'h03); stat(); setreg(1, 8'h02); stat();

        cur_req = "R6";   // row up through 63 -> 0
        setreg(0, 8'h05);
        cur_req = "R2";   // register 5 stays selected
        cyc(1, 0, 0, 1, 8'd62); cyc(1, 0, 0, 1, 8'h83);
        cur_req = "R1";
        dwr(8'h11); dwr(8'h22); dwr(8'h33); dwr(8'h44); stat();

        cur_req = "R5";   // column down through 0 -> 31
        setreg(0, 8'h06); setreg(5, 8'h81);
        dwr(8'h55); dwr(8'h66); dwr(8'h77); idle();

        cur_req = "R8";   // read back row 62, column 3 upward in rows
        setreg(0, 8'h05); setreg(5, 8'd62); setreg(5, 8'h83);
        drd(); drd(); drd(); drd(); idle();
        cur_req = "R4";
        setreg(5, 8'h80); setreg(5, 8'd1);
        drd(); idle();

        cur_req = "R11";  // both strobes together: write wins
        cyc(1, 1, 1, 0, 8'h5A); idle(); setreg(5, 8'd2); drd(); idle();

        cur_req = "R7";   // temperature counter ignores direction down
        setreg(0, 8'h00); setreg(9, 8'd126);
        dwr(8'hA1); dwr(8'hA2); dwr(8'hA3); stat();
        setreg(9, 8'd126); drd(); drd(); drd(); idle();

        cur_req = "R10";  // reserved and unused register numbers
        setreg(0, 8'h05); setreg(5, 8'd10);
        for (int n = 28; n < 32; n++) setreg(n, 8'hFF);
        setreg(3, 8'hFF); setreg(12, 8'hFF);
        stat(); dwr(8'hC3); stat(); idle();

        cur_req = "R12";  // reset again mid-run
        cyc(0, 0, 0, 0, 8'h00); rst_n = 1'b0;
        idle(); idle(); rst_n = 1'b1;
        stat(); idle(); dwr(8'h9F); idle(); idle();
        summary();
    end

endmodule